// File: doc/BRIEF.md
# Fault Trap Controller with Dispatch Mask

This block gathers hardware fault conditions (arithmetic overflow, divide by zero, segment fault, illegal opcode, parity error and the like) into a bank of sticky pending bits, one per fault line. The processor pipeline does not see these bits directly. Instead, at chosen check points in its instruction cycle it strobes the block. If any bit is pending and no handler is already running, the block picks one fault, clears its pending bit and raises a call request to the fault handler. The request carries a binary condition code that names the chosen fault.

Raising the call request also sets an internal mask. While the mask is set, further check points dispatch nothing. Faults that are detected in that time are still recorded. The mask is released only by a handler-exit strobe, and the pending faults are then served one at a time at later check points. The number of fault lines is a parameter. A second parameter selects one of two encodings of the lowest-index selector; both give the same result.

Top module: `fault_trap_ctrl`

## Requirements
- R1: After reset, trap_req_o is 0, trap_code_o is 0 and no fault is pending, so a check point with no new faults raises no request.
- R2: A fault line that is high for one clock cycle is remembered. A later check point raises a request for it, even though the line has since gone low.
- R3: Pending faults are examined only when check_i is high at a clock edge. Without a check point, trap_req_o stays 0 however many faults are pending.
- R4: When several faults are pending at a check point, the one with the lowest line index is chosen.
- R5: Only the chosen fault's pending bit is cleared. Faults that were not chosen stay pending and are served at later check points, each exactly once.
- R6: trap_req_o rises in the cycle after the clock edge at which a qualifying check point is sampled. trap_code_o then equals the chosen line index as an unsigned binary number, and it holds that value for as long as trap_req_o is 1.
- R7: While trap_req_o is 1, a check point has no effect: the request and the code stay unchanged. Faults detected during that time stay pending and are dispatched after the handler exits.
- R8: exit_i, sampled high at a clock edge while a request is raised, drops trap_req_o in the next cycle. exit_i while no request is raised does nothing. When exit_i and check_i are high at the same edge, nothing is dispatched at that edge.
- R9: If a fault line is high in the same cycle that its pending bit is being cleared by a dispatch, the bit stays set and that fault is dispatched again at a later check point.
- R10: A check point with nothing pending raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fault_i | input | N_FAULTS | Fault detect lines, one per condition, active high |
| check_i | input | 1 | Check-point strobe from the instruction cycle |
| exit_i | input | 1 | Handler-exit strobe; releases the mask |
| trap_req_o | output | 1 | Handler call request, held until handler exit |
| trap_code_o | output | CODE_W | Binary index of the dispatched fault |

## Verification
The selector is tried with one pending fault, with scattered sets such as lines 2, 5 and 7, and with all lines pending. These patterns separate a true lowest-index choice from a highest-index choice or a choice that depends on position, and they show that each bit is cleared on its own. Faults are injected while the mask is set, and check points are sent at the same time, so that faults which are lost can be told apart from faults that are dispatched early. Same-edge collisions (exit together with check, and a fault rising together with its own clear) show which event wins at the edge.

// File: rtl/ft_trap_pkg.sv
package ft_trap_pkg;
   // selector encodings for the lowest-index picker
   localparam int PICK_SCAN    = 0;   // priority loop
   localparam int PICK_ISOLATE = 1;   // two's complement isolate, then encode

   function automatic int code_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ftc_indicator_bank.sv
module ftc_indicator_bank #(
   parameter int N_FAULTS = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [N_FAULTS-1:0] set_i,
   input  logic [N_FAULTS-1:0] clr_i,
   output logic [N_FAULTS-1:0] pend_o
);
   logic [N_FAULTS-1:0] pend_q;

   // set has precedence over clear (R9)
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= (pend_q & ~clr_i) | set_i;
   end

   assign pend_o = pend_q;

   // at most one bit is cleared per dispatch (R5)
   p_clr_onehot_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(clr_i));

   for (genvar g = 0; g < N_FAULTS; g++) begin : g_bit
      // R9: a detection always leaves the bit set
      p_set_wins_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_i[g] |=> pend_q[g]);
      // R5: a cleared bit with no new detection drops
      p_clear_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_i[g] && !set_i[g]) |=> !pend_q[g]);
      // R2: a pending bit with no clear is kept
      p_hold_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (pend_q[g] && !clr_i[g]) |=> pend_q[g]);
   end
endmodule

// File: rtl/ftc_lowest_pick.sv
module ftc_lowest_pick
   import ft_trap_pkg::*;
#(
   parameter int N_FAULTS   = 8,
   parameter int PICK_STYLE = PICK_SCAN,
   localparam int CODE_W    = code_width(N_FAULTS)
) (
   input  logic [N_FAULTS-1:0] req_i,
   output logic                any_o,
   output logic [CODE_W-1:0]   idx_o
);
   assign any_o = |req_i;

   if (PICK_STYLE == PICK_SCAN) begin : g_scan
      always_comb begin
         idx_o = '0;
         for (int i = N_FAULTS - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = CODE_W'(i);
         end
      end
   end else if (PICK_STYLE == PICK_ISOLATE) begin : g_isolate
      logic [N_FAULTS-1:0] iso;
      assign iso = req_i & (~req_i + N_FAULTS'(1));
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < N_FAULTS; i++) begin
            if (iso[i]) idx_o = idx_o | CODE_W'(i);
         end
      end
   end else begin : g_bad_style
      $error("ftc_lowest_pick: unknown PICK_STYLE %0d", PICK_STYLE);
   end
endmodule

// File: rtl/ftc_dispatch_ctrl.sv
module ftc_dispatch_ctrl
   import ft_trap_pkg::*;
#(
   parameter int N_FAULTS = 8,
   localparam int CODE_W  = code_width(N_FAULTS)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                check_i,
   input  logic                exit_i,
   input  logic                any_i,
   input  logic [CODE_W-1:0]   idx_i,
   output logic [N_FAULTS-1:0] clr_o,
   output logic                mask_o,
   output logic [CODE_W-1:0]   code_o
);
   logic              mask_q;
   logic [CODE_W-1:0] code_q;
   logic              grant;

   // dispatch only at a check point, unmasked, with work pending
   assign grant = check_i & ~mask_q & any_i;

   always_comb begin
      clr_o = '0;
      for (int i = 0; i < N_FAULTS; i++) begin
         if (grant && idx_i == CODE_W'(i)) clr_o[i] = 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= 1'b0;
         code_q <= '0;
      end else begin
         if (grant) begin
            mask_q <= 1'b1;
            code_q <= idx_i;
         end else if (exit_i) begin
            mask_q <= 1'b0;
         end
      end
   end

   assign mask_o = mask_q;
   assign code_o = code_q;

   // R7: masked and no exit -> still masked, code held
   p_mask_hold_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q && !exit_i) |=> (mask_q && $stable(code_q)));
   // R8: exit while masked releases next cycle
   p_exit_clears_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q && exit_i) |=> !mask_q);
   // R3: mask rises only after a check point
   p_check_only_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mask_q) |-> $past(check_i));
endmodule

// File: rtl/fault_trap_ctrl.sv
module fault_trap_ctrl
   import ft_trap_pkg::*;
#(
   parameter int N_FAULTS   = 8,
   parameter int PICK_STYLE = PICK_SCAN,
   localparam int CODE_W    = code_width(N_FAULTS)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [N_FAULTS-1:0] fault_i,
   input  logic                check_i,
   input  logic                exit_i,
   output logic                trap_req_o,
   output logic [CODE_W-1:0]   trap_code_o
);
   if (N_FAULTS < 2 || N_FAULTS > 64) begin : g_bad_n
      $error("fault_trap_ctrl: N_FAULTS %0d outside 2..64", N_FAULTS);
   end

   logic [N_FAULTS-1:0] pend;
   logic [N_FAULTS-1:0] clr;
   logic                any_pend;
   logic [CODE_W-1:0]   pick_idx;
   logic                mask;
   logic [CODE_W-1:0]   code;

   ftc_indicator_bank #(.N_FAULTS(N_FAULTS)) i_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (fault_i),
      .clr_i  (clr),
      .pend_o (pend)
   );

   ftc_lowest_pick #(.N_FAULTS(N_FAULTS), .PICK_STYLE(PICK_STYLE)) i_pick (
      .req_i (pend),
      .any_o (any_pend),
      .idx_o (pick_idx)
   );

   ftc_dispatch_ctrl #(.N_FAULTS(N_FAULTS)) i_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .check_i (check_i),
      .exit_i  (exit_i),
      .any_i   (any_pend),
      .idx_i   (pick_idx),
      .clr_o   (clr),
      .mask_o  (mask),
      .code_o  (code)
   );

   assign trap_req_o  = mask;
   assign trap_code_o = code;

   // R4: the picked index names a pending bit with none below it
   p_pick_lowest_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_pend |-> (pend[pick_idx] &&
                    ((pend & ((N_FAULTS'(1) << pick_idx) - N_FAULTS'(1))) == '0)));
   // R6: code stable while the request stays up
   p_code_stable_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_req_o |=> (!trap_req_o || $stable(trap_code_o)));
   // R10: no request rises when nothing was pending
   p_no_empty_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trap_req_o && !any_pend) |=> !trap_req_o);
endmodule

// File: tb/test_fault_trap_ctrl.sv
module test_fault_trap_ctrl;
   localparam int N  = 8;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  fault = '0;
   logic          check = 1'b0;
   logic          ex = 1'b0;
   logic          trap_req;
   logic [CW-1:0] trap_code;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;
   int exp_q[$];

   always #10 clk = ~clk;   // 50 MHz

   fault_trap_ctrl #(.N_FAULTS(N)) i_fault_trap_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .check_i(check),
      .exit_i(ex), .trap_req_o(trap_req), .trap_code_o(trap_code)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: pops expected code on every new request, checks hold
   logic          prev_req = 1'b0;
   logic [CW-1:0] prev_code = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (trap_req && !prev_req) begin
            if (exp_q.size() == 0) chk("R3 unexpected request", 1, 0);
            else chk("R4 dispatched code", int'(trap_code), exp_q.pop_front());
         end else if (trap_req && prev_req) begin
            chk("R6 code held", int'(trap_code), int'(prev_code));
         end
      end
      prev_req  = trap_req;
      prev_code = trap_code;
   end

   task automatic pulse(input logic [N-1:0] f);
      @(negedge clk); fault = f;
      @(negedge clk); fault = '0;
   endtask

   // check point; exp_on: request expected afterwards
   task automatic check_pt(input bit push, input int code, input bit exp_on, input string req);
      @(negedge clk); check = 1'b1;
      if (push) exp_q.push_back(code);
      @(negedge clk); check = 1'b0;
      chk(req, int'(trap_req), int'(exp_on));
   endtask

   task automatic do_exit(input string req);
      @(negedge clk); ex = 1'b1;
      @(negedge clk); ex = 1'b0;
      chk(req, int'(trap_req), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 request after reset", int'(trap_req), 0);
      chk("R1 code after reset", int'(trap_code), 0);
      check_pt(0, 0, 0, "R1 nothing pending after reset");
      check_pt(0, 0, 0, "R10 empty check point");

      // R2, R3, R6: single fault, no check for a while
      pulse(8'h08);
      repeat (5) @(negedge clk);
      chk("R3 no check point, no request", int'(trap_req), 0);
      check_pt(1, 3, 1, "R2 latched fault dispatched");
      chk("R6 code equals index 3", int'(trap_code), 3);
      do_exit("R8 exit drops request");

      // R4, R5: scattered set 2,5,7
      pulse(8'hA4);
      check_pt(1, 2, 1, "R4 lowest of 2,5,7");
      do_exit("R8 exit");
      check_pt(1, 5, 1, "R5 next of 5,7");
      do_exit("R8 exit");
      check_pt(1, 7, 1, "R5 last of set");
      do_exit("R8 exit");
      check_pt(0, 0, 0, "R5 each served once");

      // R7: masked check point and fault arriving while masked
      pulse(8'h01);
      check_pt(1, 0, 1, "R7 dispatch line 0");
      pulse(8'h02);
      check_pt(0, 0, 1, "R7 masked check keeps request");
      chk("R7 masked check keeps code", int'(trap_code), 0);
      do_exit("R8 exit");
      check_pt(1, 1, 1, "R7 fault during mask not lost");
      do_exit("R8 exit");

      // R8: exit while idle does nothing
      pulse(8'h10);
      do_exit("R8 idle exit no request");
      check_pt(1, 4, 1, "R8 idle exit left fault pending");
      do_exit("R8 exit");

      // R8: exit and check at same edge -> no dispatch
      pulse(8'h40);
      check_pt(1, 6, 1, "R4 dispatch line 6");
      pulse(8'h20);
      @(negedge clk); ex = 1'b1; check = 1'b1;
      @(negedge clk); ex = 1'b0; check = 1'b0;
      chk("R8 exit with check, no dispatch", int'(trap_req), 0);
      check_pt(1, 5, 1, "R8 fault kept after collision");
      do_exit("R8 exit");

      // R9: detection in the clearing cycle wins
      pulse(8'h08);
      @(negedge clk); fault = 8'h08; check = 1'b1; exp_q.push_back(3);
      @(negedge clk); fault = '0; check = 1'b0;
      chk("R9 dispatch during re-detect", int'(trap_req), 1);
      do_exit("R8 exit");
      check_pt(1, 3, 1, "R9 re-detected fault pending again");
      do_exit("R8 exit");
      check_pt(0, 0, 0, "R10 empty after R9");

      // R4, R5: all lines pending
      pulse('1);
      for (int k = 0; k < N; k++) begin
         check_pt(1, k, 1, "R5 all-pending order");
         do_exit("R8 exit");
      end
      check_pt(0, 0, 0, "R5 all served");

      repeat (3) @(negedge clk);
      chk("R3 scoreboard drained", exp_q.size(), 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule